// File: doc/BRIEF.md
# Posted Write Buffer with Disconnect Replay

This block holds posted writes between a burst-capable slave port and a master port that forwards them onward. The slave port writes one address entry per burst, followed by one or more data entries. Each entry carries a 32-bit word (the width is a parameter and can be 64), a command code, byte enables, an address/data tag bit and a last-beat flag. The address is stored once per burst, not once per beat, so the buffer stays narrow.

The master port pops the address entry, loads it into a running address counter and runs an address phase. It then presents data entries one per data phase. A data entry leaves the buffer only when the target accepts it. When the target disconnects in the middle of a burst, the engine runs a new address phase at the counter value, which is the address of the first beat not yet accepted. It then carries on with the remaining entries. The writes were already acknowledged upstream, so no beat is ever dropped.

Top module: `pwb_top`

## Requirements
- R1: While reset is held low and on the first cycle after it, out_addr_valid and out_data_valid are 0 and in_full is 0.
- R2: An entry pushed with in_tag=1 is an address entry. It produces an address phase: out_addr_valid=1 with out_addr equal to the pushed word and out_cmd equal to the pushed command. Both hold steady until tgt_accept is 1.
- R3: Entries pushed with in_tag=0 are data entries. They appear on out_data/out_be/out_last in push order, and only after the address phase of their burst has been accepted. Each entry stays on the port until tgt_accept takes it.
- R4: Each accepted data beat advances the address counter by DATA_W/8, which is 4 at the default width.
- R5: If tgt_disconnect=1 and tgt_accept=0 during a data phase, the beat is kept. The next cycle shows an address phase at the address of that beat, and the same beat is presented again once that phase is accepted.
- R6: If tgt_accept=1 and tgt_disconnect=1 during a non-last data phase, the beat is consumed. A new address phase follows at the address of the next beat.
- R7: Acceptance of a beat with out_last=1 ends the burst, even if tgt_disconnect is 1. The next action is the address phase of the following burst, with no address phase for the finished one.
- R8: in_full is 1 once DEPTH entries are held. A push while in_full=1 is ignored and leaves the stored entries unchanged.
- R9: During a burst, when no data entry is buffered, out_data_valid stays 0 and the engine waits without popping.
- R10: out_addr_valid and out_data_valid are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Push request from the slave side |
| in_tag | input | 1 | 1 = address entry, 0 = data entry |
| in_last | input | 1 | Final data entry of a burst |
| in_word | input | DATA_W | Address or data word |
| in_cmd | input | CMD_W | Bus command (used from address entries) |
| in_be | input | DATA_W/8 | Byte enables |
| in_full | output | 1 | Buffer holds DEPTH entries |
| out_addr_valid | output | 1 | Address phase requested |
| out_addr | output | DATA_W | Address counter value for the address phase |
| out_cmd | output | CMD_W | Command of the current burst |
| out_data_valid | output | 1 | Data phase presented |
| out_data | output | DATA_W | Data word of the head entry |
| out_be | output | DATA_W/8 | Byte enables of the head entry |
| out_last | output | 1 | Head entry ends the burst |
| tgt_accept | input | 1 | Target takes the current phase |
| tgt_disconnect | input | 1 | Target ends the data transfer |

## Verification
The bench targets the following faults:
- **Disconnect with no accept.** The bench forces this on early, middle and last beats. A design that dropped the beat, or that did not send a fresh address phase, would show data while an address is expected, or a wrong word.
- **Accept together with disconnect.** If the counter did not advance, or the design restarted after the last beat, the next address would be off by one beat, or an extra address phase would appear.
- **Writes into a full buffer.** Address entries are pushed while the buffer is full. If one were stored, it would overwrite the head entry or surface later as a stray address phase.
- **Producer running behind the target.** The producer is slowed at random so data phases run while the buffer is empty. This exposes a design that presents a stale word.

// File: rtl/pwb_pkg.sv
// Shared definitions for the posted write buffer.
// Assumes: nothing beyond standard SystemVerilog.
package pwb_pkg;

    // Value of the tag bit that marks an address entry.
    localparam logic ENTRY_IS_ADDR = 1'b1;

    // Phases of the master-side replay sequencer.
    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_ADDR = 2'd1,
        RP_DATA = 2'd2
    } rp_state_e;

endpackage

// File: rtl/pwb_fifo.sv
// Single-clock buffer of tagged write entries with a show-ahead head.
// Assumes: DEPTH is a power of two; pointers carry one extra wrap bit.
// A push while full and a pop while empty are ignored.
module pwb_fifo #(
    parameter int EW    = 42,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] wdata,
    input  logic          pop,
    output logic [EW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [EW-1:0] mem [DEPTH];
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    // Store an accepted entry at the write slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr[AW-1:0]] <= wdata;
        end
    end

    // Advance the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R8: a full buffer stays full unless an entry leaves.
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R8: a push while full does not move the write pointer.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> (wr_ptr == $past(wr_ptr)));

    // R9: nothing leaves an empty buffer.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop) |=> (rd_ptr == $past(rd_ptr)));

endmodule

// File: rtl/pwb_replay.sv
// Master-side sequencer: pops the address entry, keeps a running beat
// address, presents data entries and re-runs the address phase after a
// target disconnect. A data entry is popped only when accepted.
// Assumes: bursts arrive well formed (address entry, then data entries,
// the final one flagged last).
module pwb_replay
    import pwb_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_valid,
    input  logic            head_tag,
    input  logic            head_last,
    input  logic [DW-1:0]   head_word,
    input  logic [CW-1:0]   head_cmd,
    input  logic [DW/8-1:0] head_be,
    output logic            pop,
    output logic            out_addr_valid,
    output logic [DW-1:0]   out_addr,
    output logic [CW-1:0]   out_cmd,
    output logic            out_data_valid,
    output logic [DW-1:0]   out_data,
    output logic [DW/8-1:0] out_be,
    output logic            out_last,
    input  logic            tgt_accept,
    input  logic            tgt_disconnect
);
    localparam logic [DW-1:0] STEP = DW'(DW / 8);

    rp_state_e     state;
    logic [DW-1:0] addr_cnt;
    logic [CW-1:0] cmd_q;

    assign out_addr_valid = (state == RP_ADDR);
    assign out_addr       = addr_cnt;
    assign out_cmd        = cmd_q;
    assign out_data_valid = (state == RP_DATA) && head_valid;
    assign out_data       = head_word;
    assign out_be         = head_be;
    assign out_last       = head_last;

    // Decide when the head entry leaves the buffer.
    always_comb begin
        pop = 1'b0;
        case (state)
            RP_IDLE: pop = head_valid && (head_tag == ENTRY_IS_ADDR);
            RP_DATA: pop = head_valid && tgt_accept;
            default: pop = 1'b0;
        endcase
    end

    // Sequence the address and data phases and keep the beat address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RP_IDLE;
            addr_cnt <= '0;
            cmd_q    <= '0;
        end else begin
            case (state)
                RP_IDLE: begin
                    if (pop) begin
                        addr_cnt <= head_word;
                        cmd_q    <= head_cmd;
                        state    <= RP_ADDR;
                    end
                end
                RP_ADDR: begin
                    if (tgt_accept) state <= RP_DATA;
                end
                RP_DATA: begin
                    if (head_valid) begin
                        if (tgt_accept) begin
                            addr_cnt <= addr_cnt + STEP;
                            if (head_last)           state <= RP_IDLE;
                            else if (tgt_disconnect) state <= RP_ADDR;
                        end else if (tgt_disconnect) begin
                            state <= RP_ADDR;
                        end
                    end
                end
                default: state <= RP_IDLE;
            endcase
        end
    end

    // R1: the cycle after reset shows no phase.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_addr_valid && !out_data_valid));

    // R2: an address phase holds its address until taken.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_addr_valid && !tgt_accept) |=> (out_addr_valid && $stable(out_addr)));

    // R4: an accepted non-last beat advances the address by one beat.
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data_valid && tgt_accept && !out_last) |=> (out_addr == $past(out_addr) + STEP));

    // R5: a refused disconnect re-runs the address phase.
    p_disc_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data_valid && tgt_disconnect && !tgt_accept) |=> out_addr_valid);

    // R7: the last beat accepted closes the burst without a new address phase.
    p_last_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data_valid && tgt_accept && out_last) |=> !out_addr_valid && !out_data_valid);

    // R10: never an address phase and a data phase at once.
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_addr_valid && out_data_valid));

endmodule

// File: rtl/pwb_top.sv
// Posted write buffer: tagged entry storage plus a replay sequencer on
// the master side. Entry layout is {tag, last, cmd, be, word}.
// Assumes: single clock, DEPTH a power of two, DATA_W a multiple of 8.
module pwb_top #(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_tag,
    input  logic                in_last,
    input  logic [DATA_W-1:0]   in_word,
    input  logic [CMD_W-1:0]    in_cmd,
    input  logic [DATA_W/8-1:0] in_be,
    output logic                in_full,
    output logic                out_addr_valid,
    output logic [DATA_W-1:0]   out_addr,
    output logic [CMD_W-1:0]    out_cmd,
    output logic                out_data_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic [DATA_W/8-1:0] out_be,
    output logic                out_last,
    input  logic                tgt_accept,
    input  logic                tgt_disconnect
);
    localparam int BEW = DATA_W / 8;
    localparam int EW  = 2 + CMD_W + BEW + DATA_W;

    logic [EW-1:0]     wr_entry;
    logic [EW-1:0]     rd_entry;
    logic              fifo_empty;
    logic              fifo_pop;
    logic              h_tag;
    logic              h_last;
    logic [CMD_W-1:0]  h_cmd;
    logic [BEW-1:0]    h_be;
    logic [DATA_W-1:0] h_word;

    assign wr_entry = {in_tag, in_last, in_cmd, in_be, in_word};
    assign {h_tag, h_last, h_cmd, h_be, h_word} = rd_entry;

    pwb_fifo #(.EW(EW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .wdata (wr_entry),
        .pop   (fifo_pop),
        .rdata (rd_entry),
        .full  (in_full),
        .empty (fifo_empty)
    );

    pwb_replay #(.DW(DATA_W), .CW(CMD_W)) u_replay (
        .clk            (clk),
        .rst_n          (rst_n),
        .head_valid     (!fifo_empty),
        .head_tag       (h_tag),
        .head_last      (h_last),
        .head_word      (h_word),
        .head_cmd       (h_cmd),
        .head_be        (h_be),
        .pop            (fifo_pop),
        .out_addr_valid (out_addr_valid),
        .out_addr       (out_addr),
        .out_cmd        (out_cmd),
        .out_data_valid (out_data_valid),
        .out_data       (out_data),
        .out_be         (out_be),
        .out_last       (out_last),
        .tgt_accept     (tgt_accept),
        .tgt_disconnect (tgt_disconnect)
    );

endmodule

// File: tb/test_pwb_top.sv
// Bench for pwb_top: acts as producer and as target, tracking the
// expected beat address and burst position in its own model.
module test_pwb_top;
    localparam int DW    = 32;
    localparam int CW    = 4;
    localparam int BEW   = DW / 8;
    localparam int DEPTH = 8;
    localparam int NB    = 40;
    localparam int MAXB  = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid, in_tag, in_last;
    logic [DW-1:0]  in_word;
    logic [CW-1:0]  in_cmd;
    logic [BEW-1:0] in_be;
    logic           in_full;
    logic           out_addr_valid, out_data_valid, out_last;
    logic [DW-1:0]  out_addr, out_data;
    logic [CW-1:0]  out_cmd;
    logic [BEW-1:0] out_be;
    logic           tgt_accept, tgt_disconnect;

    pwb_top #(.DATA_W(DW), .CMD_W(CW), .DEPTH(DEPTH)) i_pwb_top (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_tag(in_tag), .in_last(in_last),
        .in_word(in_word), .in_cmd(in_cmd), .in_be(in_be), .in_full(in_full),
        .out_addr_valid(out_addr_valid), .out_addr(out_addr), .out_cmd(out_cmd),
        .out_data_valid(out_data_valid), .out_data(out_data), .out_be(out_be),
        .out_last(out_last), .tgt_accept(tgt_accept), .tgt_disconnect(tgt_disconnect)
    );

    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [DW-1:0]  b_base [NB];
    logic [CW-1:0]  b_cmd  [NB];
    int             b_len  [NB];
    logic [DW-1:0]  b_dat  [NB][MAXB];
    logic [BEW-1:0] b_be   [NB][MAXB];

    // Expected address of beat k of burst b.
    function automatic logic [DW-1:0] exp_addr(int b, int k);
        return b_base[b] + DW'(k * BEW);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_tag = 1'b0; in_last = 1'b0;
        in_word = '0; in_cmd = '0; in_be = '0;
        tgt_accept = 1'b0; tgt_disconnect = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_addr_valid && !out_data_valid, "R1 valids in reset",
            {out_addr_valid, out_data_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_addr_valid && !out_data_valid && !in_full, "R1 after reset",
            {in_full, out_addr_valid, out_data_valid}, 0);
    endtask

    task automatic push1(input logic tag, input logic last, input logic [DW-1:0] w,
                         input logic [CW-1:0] c, input logic [BEW-1:0] be);
        in_valid = 1'b1; in_tag = tag; in_last = last; in_word = w; in_cmd = c; in_be = be;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Target and optional producer; checks every presented phase.
    task automatic run(input bit do_push, input int nb);
        int  mb = 0, md = 0, pb = 0, pk = -1;
        bit  need_addr = 1'b1;
        while (mb < nb) begin
            int r;
            tgt_accept = 1'b0; tgt_disconnect = 1'b0; in_valid = 1'b0;
            cycles++;
            if (cycles > 20000) begin
                chk(1'b0, "watchdog", cycles, 20000);
                break;
            end
            chk(!(out_addr_valid && out_data_valid), "R10 exclusive phases",
                {out_addr_valid, out_data_valid}, 2'b00);
            if (out_addr_valid) begin
                chk(need_addr, "R2/R5 address phase expected", 1, need_addr);
                chk(out_addr == exp_addr(mb, md), "R4 address counter", out_addr, exp_addr(mb, md));
                chk(out_cmd == b_cmd[mb], "R2 command", out_cmd, b_cmd[mb]);
                if ($urandom % 10 < 7) begin
                    tgt_accept = 1'b1;
                    need_addr = 1'b0;
                end
            end else if (out_data_valid) begin
                chk(!need_addr, "R3/R5 data before address phase", 1, 0);
                chk(out_data == b_dat[mb][md], "R3 data order", out_data, b_dat[mb][md]);
                chk(out_be == b_be[mb][md], "R3 byte enables", out_be, b_be[mb][md]);
                chk(out_last == (md == b_len[mb] - 1), "R3 last flag", out_last, (md == b_len[mb] - 1));
                r = $urandom % 100;
                if (r < 55) begin
                    tgt_accept = 1'b1;
                end else if (r < 70) begin
                    tgt_disconnect = 1'b1;
                    need_addr = 1'b1;                 // R5
                end else if (r < 85) begin
                    tgt_accept = 1'b1; tgt_disconnect = 1'b1;   // R6 / R7
                end
                if (tgt_accept) begin
                    if (md == b_len[mb] - 1) begin
                        mb++; md = 0; need_addr = 1'b1;          // R7
                    end else begin
                        md++;
                        if (tgt_disconnect) need_addr = 1'b1;    // R6
                    end
                end
            end
            if (do_push && pb < nb && !in_full && ($urandom % 4 != 0)) begin
                in_valid = 1'b1;
                if (pk < 0) begin
                    in_tag = 1'b1; in_last = 1'b0; in_word = b_base[pb];
                    in_cmd = b_cmd[pb]; in_be = '0;
                end else begin
                    in_tag = 1'b0; in_last = (pk == b_len[pb] - 1);
                    in_word = b_dat[pb][pk]; in_cmd = '0; in_be = b_be[pb][pk];
                end
                if (pk == b_len[pb] - 1) begin
                    pb++; pk = -1;
                end else begin
                    pk++;
                end
            end
            @(negedge clk);
        end
        tgt_accept = 1'b0; tgt_disconnect = 1'b0; in_valid = 1'b0;
        // R8 / R7: nothing further appears once every burst is done.
        repeat (6) begin
            @(negedge clk);
            chk(!out_addr_valid && !out_data_valid, "R8 no stray phase after drain",
                {out_addr_valid, out_data_valid}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Directed: fill the buffer while the target holds off (R8, R2, R9).
        do_reset();
        b_base[0] = 32'h0000_1000; b_cmd[0] = 4'h7; b_len[0] = MAXB;
        for (int k = 0; k < MAXB; k++) begin
            b_dat[0][k] = 32'hA500_0000 + k;
            b_be[0][k]  = BEW'(k + 1);
        end
        push1(1'b1, 1'b0, b_base[0], b_cmd[0], '0);
        for (int k = 0; k < MAXB; k++)
            push1(1'b0, k == MAXB - 1, b_dat[0][k], 4'h0, b_be[0][k]);
        chk(in_full == 1'b1, "R8 full after DEPTH entries", in_full, 1);
        chk(out_addr_valid && out_addr == b_base[0], "R2 address held while not taken",
            out_addr, b_base[0]);
        push1(1'b1, 1'b0, 32'hDEAD_0000, 4'hF, '0);
        push1(1'b1, 1'b0, 32'hBEEF_0000, 4'hE, '0);
        chk(in_full == 1'b1, "R8 still full after ignored pushes", in_full, 1);
        run(1'b0, 1);
        chk(in_full == 1'b0, "R8 drained", in_full, 0);

        // Random bursts with a slowed producer and a noisy target.
        do_reset();
        for (int b = 0; b < NB; b++) begin
            b_base[b] = {$urandom % 32'h0010_0000, 2'b00} ;
            b_cmd[b]  = CW'($urandom);
            b_len[b]  = 1 + ($urandom % 6);
            for (int k = 0; k < MAXB; k++) begin
                b_dat[b][k] = $urandom;
                b_be[b][k]  = BEW'($urandom);
            end
        end
        run(1'b1, NB);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule